// File: doc/BRIEF.md
# Serial Port Output Flag Controller

This block holds the 24-bit control word of a synchronous serial audio port and drives three general-purpose output flags onto the port's receiver-side pins. When the transmitter and receiver share one clock (synchronous mode), the receiver's bit-clock, frame-sync and high-frequency-clock pins are free. Any of them whose direction input marks it as an output can then carry a flag bit written by software.

A flag value does not reach its pin when software writes it. Each pin has a holding register that loads the flag bit only on a protocol boundary. In normal mode that boundary is the frame-start strobe. In network mode it is the slot-start strobe. Software can therefore rewrite the flags at any time without disturbing a frame or slot in progress. The shifters, the clock generators and the meaning of the other control fields belong to other blocks.

Top module: `sflag_ctl`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) clears the control word, every pin output enable and every pin data bit.
- R2: A write (`wr_en` high) stores only bits 0, 1 and 2 (flags 0 to 2), bit 6 (sync mode), bit 7 (frame-sync exclusion) and bit 8. Bits 3 to 5 and 9 to 23 always read as zero. `rdata` shows the stored word from the edge after the write.
- R3: `soft_rst` clears the whole control word at the next edge and takes priority over a write in the same cycle. It leaves the pin holding registers unchanged.
- R4: Pin i (0 = receiver clock, 1 = receiver frame sync, 2 = high-frequency clock) is claimed when bit 6 is set and `dir[i]` is set. Pin 1 additionally needs bit 7 clear. `pin_oe[i]` shows the claim one clock after the control word and `dir` establish it.
- R5: In normal mode (`net_mode` = 0), a claimed pin's data loads its flag bit on a `frame_start` cycle. `slot_start` has no effect.
- R6: In network mode (`net_mode` = 1), a claimed pin's data loads its flag bit on a `slot_start` cycle. `frame_start` has no effect.
- R7: A pin that is not claimed keeps its last data value across boundary strobes. After it is claimed again, it picks up the current flag bit at the next boundary.
- R8: When a write and a boundary strobe fall in the same cycle, the pin loads the flag value held before that write.
- R9: With bit 6 clear, no pin is claimed. All output enables are low and no holding register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset of the control word |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Stored control word |
| net_mode | input | 1 | 1 = network mode (slot boundaries), 0 = normal mode (frame boundaries) |
| dir | input | 3 | Pin direction bits (1 = output), index as in R4 |
| frame_start | input | 1 | One-cycle frame-start strobe |
| slot_start | input | 1 | One-cycle time-slot-start strobe |
| pin_oe | output | 3 | Output enable per pin |
| pin_do | output | 3 | Flag data per pin |

## Verification
The bench targets a write that lands in the same cycle as a boundary strobe. A design that let the new value through would put it on the pin one boundary early. It drives the strobe that the current mode should ignore, which catches a design that mixes the two boundary kinds. It withdraws the claim on a single pin, and on frame sync through bit 7 alone, then strobes. A design that still updated the released pin, or cleared it, would show the wrong data when the pin is claimed again. Finally, it checks that a software reset clears the word but leaves the pin data alone, and that reserved bits never read back as ones.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int CTL_W    = 24;
  localparam int N_FLAG   = 3;
  localparam int SYNC_BIT = 6;
  localparam int EXCL_BIT = 7;
  localparam int AUX_BIT  = 8;
  localparam int FS_LANE  = 1;

  typedef enum logic {BND_FRAME = 1'b0, BND_SLOT = 1'b1} bnd_kind_e;

  function automatic logic [CTL_W-1:0] wr_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_FLAG; i++) m[i] = 1'b1;
    m[SYNC_BIT] = 1'b1;
    m[EXCL_BIT] = 1'b1;
    m[AUX_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sflag_ctl_reg.sv
module sflag_ctl_reg #(
  parameter int W = 24,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) ctl_q <= '0;
    else if (wr_en)      ctl_q <= wdata & MASK;
  end
endmodule

// File: rtl/sflag_bound_sel.sv
module sflag_bound_sel
  import sflag_pkg::*;
(
  input  logic net_mode,
  input  logic frame_start,
  input  logic slot_start,
  output logic bound
);
  bnd_kind_e kind;
  always_comb begin
    kind  = net_mode ? BND_SLOT : BND_FRAME;
    bound = (kind == BND_SLOT) ? slot_start : frame_start;
  end
endmodule

// File: rtl/sflag_lane.sv
module sflag_lane (
  input  logic clk,
  input  logic rst,
  input  logic claim,
  input  logic bound,
  input  logic flag_bit,
  output logic oe_q,
  output logic do_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      do_q <= 1'b0;
    end else begin
      oe_q <= claim;
      if (claim && bound) do_q <= flag_bit;
    end
  end
endmodule

// File: rtl/sflag_ctl.sv
module sflag_ctl
  import sflag_pkg::*;
#(
  parameter int W  = CTL_W,
  parameter int NF = N_FLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          net_mode,
  input  logic [NF-1:0] dir,
  input  logic          frame_start,
  input  logic          slot_start,
  output logic [NF-1:0] pin_oe,
  output logic [NF-1:0] pin_do
);
  localparam logic [W-1:0] MASK = W'(wr_mask());

  logic [W-1:0]  ctl_q;
  logic          bound;
  logic [NF-1:0] claim;

  sflag_ctl_reg #(.W(W), .MASK(MASK)) u_reg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wdata(wdata), .ctl_q(ctl_q)
  );

  sflag_bound_sel u_bnd (
    .net_mode(net_mode), .frame_start(frame_start),
    .slot_start(slot_start), .bound(bound)
  );

  for (genvar i = 0; i < NF; i++) begin : g_lane
    if (i == FS_LANE) begin : g_excl
      assign claim[i] = ctl_q[SYNC_BIT] & dir[i] & ~ctl_q[EXCL_BIT];
    end else begin : g_plain
      assign claim[i] = ctl_q[SYNC_BIT] & dir[i];
    end
    sflag_lane u_lane (
      .clk(clk), .rst(rst), .claim(claim[i]), .bound(bound),
      .flag_bit(ctl_q[i]), .oe_q(pin_oe[i]), .do_q(pin_do[i])
    );
  end

  assign rdata = ctl_q;
endmodule

// File: rtl/sflag_ctl_chk.sv
module sflag_ctl_chk
  import sflag_pkg::*;
#(
  parameter int W  = CTL_W,
  parameter int NF = N_FLAG
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic [W-1:0]  rdata,
  input logic          net_mode,
  input logic [NF-1:0] dir,
  input logic          frame_start,
  input logic          slot_start,
  input logic [NF-1:0] pin_oe,
  input logic [NF-1:0] pin_do
);
  localparam logic [W-1:0] MASK = W'(wr_mask());
  logic bnd;
  assign bnd = net_mode ? slot_start : frame_start;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~MASK) == '0);

  p_soft_clear_r3: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> rdata == '0);

  p_oe_needs_sync_r9: assert property (@(posedge clk) disable iff (rst)
    !rdata[SYNC_BIT] |=> pin_oe == '0);

  p_no_bound_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(pin_do));

  p_fs_excl_r4: assert property (@(posedge clk) disable iff (rst)
    rdata[EXCL_BIT] |=> !pin_oe[FS_LANE]);

  for (genvar i = 0; i < NF; i++) begin : g_chk
    p_load_prior_r8: assert property (@(posedge clk) disable iff (rst)
      (bnd && rdata[SYNC_BIT] && dir[i] && !(i == FS_LANE && rdata[EXCL_BIT]))
        |=> pin_do[i] == $past(rdata[i]));
  end
endmodule

bind sflag_ctl sflag_ctl_chk #(.W(W), .NF(NF)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .rdata(rdata),
  .net_mode(net_mode), .dir(dir), .frame_start(frame_start),
  .slot_start(slot_start), .pin_oe(pin_oe), .pin_do(pin_do)
);

// File: tb/sflag_ctl_bench.sv
module sflag_ctl_bench;
  typedef struct packed {
    logic        wr;
    logic [23:0] wd;
    logic        net;
    logic [2:0]  dr;
    logic        fs;
    logic        ss;
    logic [23:0] e_rd;
    logic [2:0]  e_oe;
    logic [2:0]  e_do;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'h000047, 1'b0, 3'b111, 1'b0, 1'b0, 24'h000047, 3'b111, 3'b000},
    '{1'b0, 24'h000000, 1'b0, 3'b111, 1'b1, 1'b0, 24'h000047, 3'b111, 3'b111},
    '{1'b1, 24'h000042, 1'b0, 3'b111, 1'b1, 1'b0, 24'h000042, 3'b111, 3'b111},
    '{1'b0, 24'h000000, 1'b0, 3'b111, 1'b0, 1'b1, 24'h000042, 3'b111, 3'b111},
    '{1'b0, 24'h000000, 1'b0, 3'b111, 1'b1, 1'b0, 24'h000042, 3'b111, 3'b010},
    '{1'b1, 24'hFFFFFF, 1'b0, 3'b111, 1'b0, 1'b0, 24'h0001C7, 3'b101, 3'b010},
    '{1'b0, 24'h000000, 1'b1, 3'b111, 1'b0, 1'b1, 24'h0001C7, 3'b101, 3'b111},
    '{1'b1, 24'h000040, 1'b1, 3'b111, 1'b1, 1'b0, 24'h000040, 3'b111, 3'b111},
    '{1'b0, 24'h000000, 1'b1, 3'b110, 1'b0, 1'b1, 24'h000040, 3'b110, 3'b001},
    '{1'b1, 24'h000007, 1'b1, 3'b111, 1'b0, 1'b1, 24'h000007, 3'b000, 3'b000},
    '{1'b0, 24'h000000, 1'b1, 3'b111, 1'b0, 1'b1, 24'h000007, 3'b000, 3'b000},
    '{1'b1, 24'h000047, 1'b1, 3'b111, 1'b0, 1'b0, 24'h000047, 3'b111, 3'b000},
    '{1'b0, 24'h000000, 1'b1, 3'b111, 1'b0, 1'b1, 24'h000047, 3'b111, 3'b111}
  };
  localparam string VTAG [NV] = '{"R2 R4", "R5", "R8", "R5", "R5", "R2 R4",
    "R6 R7", "R6", "R7", "R8 R9", "R9", "R7", "R6 R7"};

  logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0, wr_en = 1'b0;
  logic [23:0] wdata = '0, rdata;
  logic net_mode = 1'b0, frame_start = 1'b0, slot_start = 1'b0;
  logic [2:0] dir = '0, pin_oe, pin_do;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sflag_ctl u_sflag_ctl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .net_mode(net_mode), .dir(dir),
    .frame_start(frame_start), .slot_start(slot_start),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    chk("R1 rdata after reset", rdata, 24'h0);
    chk("R1 oe after reset", {21'd0, pin_oe}, 24'h0);
    chk("R1 do after reset", {21'd0, pin_do}, 24'h0);

    // R4: output enable follows one clock after the claim
    dir = 3'b111; wr_en = 1'b1; wdata = 24'h000040;
    tick();
    wr_en = 1'b0;
    chk("R4 oe not yet", {21'd0, pin_oe}, 24'h0);
    tick();
    chk("R4 oe one later", {21'd0, pin_oe}, 24'h7);
    wr_en = 1'b1; wdata = 24'h0; tick(); wr_en = 1'b0; tick();

    for (int k = 0; k < NV; k++) begin
      wr_en = VEC[k].wr; wdata = VEC[k].wd; net_mode = VEC[k].net;
      dir = VEC[k].dr; frame_start = VEC[k].fs; slot_start = VEC[k].ss;
      tick();
      wr_en = 1'b0; frame_start = 1'b0; slot_start = 1'b0;
      tick();
      chk({VTAG[k], " rdata"}, rdata, VEC[k].e_rd);
      chk({VTAG[k], " oe"}, {21'd0, pin_oe}, {21'd0, VEC[k].e_oe});
      chk({VTAG[k], " do"}, {21'd0, pin_do}, {21'd0, VEC[k].e_do});
    end

    // R3: soft reset wins over a write, clears the word, keeps the pins
    soft_rst = 1'b1; wr_en = 1'b1; wdata = 24'h000047;
    tick();
    soft_rst = 1'b0; wr_en = 1'b0;
    chk("R3 word cleared", rdata, 24'h0);
    tick();
    chk("R3 oe dropped", {21'd0, pin_oe}, 24'h0);
    chk("R3 do kept", {21'd0, pin_do}, 24'h7);
    slot_start = 1'b1; tick(); slot_start = 1'b0; tick();
    chk("R9 do kept without sync", {21'd0, pin_do}, 24'h7);

    // R1: hardware reset clears the pin data
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 do after late reset", {21'd0, pin_do}, 24'h0);
    chk("R1 oe after late reset", {21'd0, pin_oe}, 24'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule